// File: doc/BRIEF.md
# Multi-Channel Phase-Aligned PWM Generator

This block drives a set of independent pulse-width-modulated outputs. Each channel has its own period, high width and phase offset, held in shadow registers that software writes over a narrow configuration port. A channel's running copy picks up the shadow values only when its counter wraps or when the whole block is realigned. As a result, a pulse is never built from a mix of old and new settings.

Realignment restarts every enabled channel's counter at zero at the same clock edge. The trigger is a falling edge on an asynchronous sync input, which first passes through a synchronizer. In manual mode, a toggle on the load strobe arms the block, and only the next falling edge realigns it. In automatic mode, every falling edge realigns it. Two further control bits shape the realignment:

- **Force bit.** When set, running pulses are cut short at once. When clear, the block waits until every enabled channel has finished its current period.
- **Start-at-sync bit.** When set, pulses restart at once after realignment. When clear, each channel stays quiet for one full period of its own first.

A soft-reset control bit holds everything idle. The power-on values of all four control bits are module parameters.

Top module: `pwm_sync_gen`

## Requirements
- R1: An enabled channel's counter runs 0..P-1, where P is the active period and a period of 0 counts as 1. The channel output is high while ((count - offset) mod P) < W, where W is the active width. The offset must be smaller than the period.
- R2: A width of 0 gives a constant-low output. A width of P or more gives a constant-high output, with no low cycle where the counter wraps.
- R3: A disabled channel drives its output low and keeps its counter at 0.
- R4: Newly written period, width and offset values reach a running channel only at its counter wrap or at a realignment. A disabled channel takes them at once.
- R5: With auto_align=0, any change of level on load_cfg sets armed_o. The next synchronized falling edge of ext_sync realigns the channels. armed_o clears when that realignment happens. A falling edge while the block is not armed has no effect.
- R6: With auto_align=1, every synchronized falling edge of ext_sync realigns the channels, and a load_cfg toggle does not set armed_o.
- R7: With force_align=1, suppose ext_sync is sampled 1 at edge k-1 and 0 at edge k. Then every enabled counter is 0 after edge k+2.
- R8: With force_align=0, a falling edge that is accepted for realignment becomes pending. Realignment happens on the first cycle in which every enabled channel has wrapped at least once since that edge. Further falling edges are ignored while the realignment is pending.
- R9: With start_at_sync=1, output follows R1 from count 0 right after realignment. With start_at_sync=0, the output stays low for P cycles after realignment and then follows R1 from count 0.
- R10: While soft_rst is 1, all counters are 0, all outputs are low, and any armed or pending state is cleared.
- R11: The control word ctl_o/ctl_wdata holds soft_rst in bit 0, start_at_sync in bit 1, force_align in bit 2 and auto_align in bit 3. After reset, these bits take the values of the parameters RST_SOFT, RST_START_AT_SYNC, RST_FORCE and RST_AUTO.
- R12: A write with cfg_we=1 goes to the channel given by cfg_ch. cfg_sel selects the field: 0 for period, 1 for width, 2 for offset, and 3 for enable, which takes cfg_data bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Channel field write strobe |
| cfg_ch | input | CHW | Channel select for the write |
| cfg_sel | input | 2 | Field select: period, width, offset or enable |
| cfg_data | input | CW | Write data |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | New control word |
| ext_sync | input | 1 | Asynchronous sync; its falling edge triggers realignment |
| load_cfg | input | 1 | Level toggle that arms manual-mode realignment |
| pwm_o | output | NCH | One PWM output per channel |
| armed_o | output | 1 | Armed and waiting for a sync falling edge |
| ctl_o | output | 4 | Current control word |

## Verification
The bench steers toward channels with equal and prime periods, offsets near the period, zero and over-range widths, and a one-cycle period. A design that compares the width with the wrong sign or wraps one count late shows a stray low cycle on a 100% channel. A design that counts the synchronizer stages wrongly realigns one cycle off in force mode. Sync edges arrive in every mode: unarmed, pending in graceful mode, and during soft reset. A design that lets an unarmed or second edge through, or realigns before the slowest channel has wrapped, puts its counters out of step with the expected phases. Start-at-sync off is tried on channels whose periods differ, so a design that shares one delay across channels releases some channels too early.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
   localparam int CTL_W = 4;

   typedef enum logic [1:0] {
      SEL_PERIOD = 2'd0,
      SEL_WIDTH  = 2'd1,
      SEL_OFFSET = 2'd2,
      SEL_ENABLE = 2'd3
   } cfg_sel_e;

   // packed order gives bit3 auto, bit2 force, bit1 start-at-sync, bit0 soft reset
   typedef struct packed {
      logic auto_align;
      logic force_align;
      logic start_at_sync;
      logic soft_rst;
   } ctl_t;
endpackage

// File: rtl/pwm_sync_detect.sv
module pwm_sync_detect #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_sync,
   output logic fall_o
);
   logic [STAGES-1:0] sh_q;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("pwm_sync_detect: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         last_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], ext_sync};
         last_q <= sh_q[STAGES-1];
      end
   end

   assign fall_o = last_q & ~sh_q[STAGES-1];

   // R5: a detected edge lasts exactly one cycle
   a_r5_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);
endmodule

// File: rtl/pwm_align_ctrl.sv
module pwm_align_ctrl #(
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           soft_rst,
   input  logic           force_align,
   input  logic           auto_align,
   input  logic           sync_fall,
   input  logic           load_cfg,
   input  logic [NCH-1:0] chan_en,
   input  logic [NCH-1:0] chan_wrap,
   output logic           align_o,
   output logic           armed_o
);
   logic           load_q;
   logic           armed_q;
   logic           pend_q;
   logic [NCH-1:0] done_q;
   logic           trig;
   logic           all_done;
   logic           accept;
   logic           toggle;

   assign toggle   = load_cfg ^ load_q;
   assign trig     = sync_fall & (auto_align | armed_q);
   assign all_done = &(done_q | ~chan_en);
   assign accept   = ~force_align & trig & ~pend_q;
   assign align_o  = (force_align ? trig : (pend_q & all_done)) & ~soft_rst;
   assign armed_o  = armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q  <= 1'b0;
         armed_q <= 1'b0;
         pend_q  <= 1'b0;
         done_q  <= '0;
      end else begin
         load_q <= load_cfg;
         if (soft_rst) begin
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
            done_q  <= '0;
         end else begin
            if (align_o)                   armed_q <= 1'b0;
            else if (toggle && !auto_align) armed_q <= 1'b1;

            if (accept)      done_q <= '0;
            else if (pend_q) done_q <= done_q | (chan_wrap & chan_en);

            if (align_o)     pend_q <= 1'b0;
            else if (accept) pend_q <= 1'b1;
         end
      end
   end

   a_r5_armed_clears: assert property (@(posedge clk) disable iff (!rst_n)
      align_o |=> !armed_q);
   a_r6_auto_never_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_align && !armed_q) |=> !armed_q);
   a_r8_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !all_done && !soft_rst && !force_align) |=> pend_q);
   a_r10_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!armed_q && !pend_q));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          align,
   input  logic          start_at_sync,
   input  logic          en,
   input  logic [CW-1:0] per_s,
   input  logic [CW-1:0] wid_s,
   input  logic [CW-1:0] off_s,
   output logic          pwm_o,
   output logic          wrap_o
);
   logic [CW-1:0] per_a, wid_a, off_a, cnt_q, per_eff;
   logic          run_q;
   logic          last;
   logic [CW:0]   c1, p1, o1, phase;
   logic          hit;

   assign per_eff = (per_a == '0) ? CW'(1) : per_a;
   assign last    = (cnt_q == per_eff - CW'(1));
   assign wrap_o  = en & last;

   assign c1    = {1'b0, cnt_q};
   assign p1    = {1'b0, per_eff};
   assign o1    = {1'b0, off_a};
   assign phase = (c1 >= o1) ? (c1 - o1) : (c1 + p1 - o1);
   assign hit   = ({1'b0, wid_a} > phase);
   assign pwm_o = en & run_q & ~soft_rst & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b1;
         per_a <= '0;
         wid_a <= '0;
         off_a <= '0;
      end else if (soft_rst || !en) begin
         cnt_q <= '0;
         run_q <= 1'b1;
         per_a <= per_s;
         wid_a <= wid_s;
         off_a <= off_s;
      end else if (align || last) begin
         cnt_q <= '0;
         run_q <= align ? start_at_sync : 1'b1;
         per_a <= per_s;
         wid_a <= wid_s;
         off_a <= off_s;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < per_eff);
   a_r2_full_width_high: assert property (@(posedge clk) disable iff (!rst_n)
      (en && run_q && !soft_rst && wid_a >= per_eff) |-> pwm_o);
   a_r3_disabled_counter_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0));
   a_r4_settings_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !soft_rst && !align && !last) |=>
         ($stable(per_a) && $stable(wid_a) && $stable(off_a)));
endmodule

// File: rtl/pwm_sync_gen.sv
module pwm_sync_gen
   import pwm_sync_pkg::*;
#(
   parameter int NCH               = 4,
   parameter int CW                = 16,
   parameter int SYNC_STAGES       = 2,
   parameter bit RST_SOFT          = 1'b0,
   parameter bit RST_START_AT_SYNC = 1'b1,
   parameter bit RST_FORCE         = 1'b1,
   parameter bit RST_AUTO          = 1'b0,
   localparam int CHW              = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CHW-1:0]   cfg_ch,
   input  logic [1:0]       cfg_sel,
   input  logic [CW-1:0]    cfg_data,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             ext_sync,
   input  logic             load_cfg,
   output logic [NCH-1:0]   pwm_o,
   output logic             armed_o,
   output logic [CTL_W-1:0] ctl_o
);
   if (NCH < 1) begin : g_bad_nch
      $error("pwm_sync_gen: NCH must be at least 1");
   end
   if (CW < 2) begin : g_bad_cw
      $error("pwm_sync_gen: CW must be at least 2");
   end

   ctl_t           ctl_q;
   logic           sync_fall;
   logic           align;
   logic [NCH-1:0] en_vec;
   logic [NCH-1:0] wrap_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '{auto_align:    RST_AUTO,
                    force_align:   RST_FORCE,
                    start_at_sync: RST_START_AT_SYNC,
                    soft_rst:      RST_SOFT};
      end else if (ctl_we) begin
         ctl_q <= ctl_t'(ctl_wdata);
      end
   end
   assign ctl_o = ctl_q;

   pwm_sync_detect #(.STAGES(SYNC_STAGES)) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_sync (ext_sync),
      .fall_o   (sync_fall)
   );

   pwm_align_ctrl #(.NCH(NCH)) u_align (
      .clk         (clk),
      .rst_n       (rst_n),
      .soft_rst    (ctl_q.soft_rst),
      .force_align (ctl_q.force_align),
      .auto_align  (ctl_q.auto_align),
      .sync_fall   (sync_fall),
      .load_cfg    (load_cfg),
      .chan_en     (en_vec),
      .chan_wrap   (wrap_vec),
      .align_o     (align),
      .armed_o     (armed_o)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic [CW-1:0] per_s, wid_s, off_s;
      logic          en_s;
      logic          hit_w;

      assign hit_w = cfg_we && (cfg_ch == CHW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            per_s <= '0;
            wid_s <= '0;
            off_s <= '0;
            en_s  <= 1'b0;
         end else if (hit_w) begin
            unique case (cfg_sel_e'(cfg_sel))
               SEL_PERIOD: per_s <= cfg_data;
               SEL_WIDTH:  wid_s <= cfg_data;
               SEL_OFFSET: off_s <= cfg_data;
               SEL_ENABLE: en_s  <= cfg_data[0];
            endcase
         end
      end

      assign en_vec[g] = en_s;

      pwm_chan #(.CW(CW)) u_chan (
         .clk           (clk),
         .rst_n         (rst_n),
         .soft_rst      (ctl_q.soft_rst),
         .align         (align),
         .start_at_sync (ctl_q.start_at_sync),
         .en            (en_s),
         .per_s         (per_s),
         .wid_s         (wid_s),
         .off_s         (off_s),
         .pwm_o         (pwm_o[g]),
         .wrap_o        (wrap_vec[g])
      );
   end

   a_r10_soft_outputs_low: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q.soft_rst |-> (pwm_o == '0));
endmodule

// File: tb/sim_pwm_sync_gen.sv
module sim_pwm_sync_gen;
   localparam int  CLK_PERIOD = 10;
   localparam int  NCH = 4;
   localparam int  CW  = 16;
   localparam int  CHW = 2;
   localparam bit  P_SOFT = 1'b0, P_SAS = 1'b1, P_FORCE = 1'b1, P_AUTO = 1'b0;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [CHW-1:0]  cfg_ch = '0;
   logic [1:0]      cfg_sel = '0;
   logic [CW-1:0]   cfg_data = '0;
   logic            ctl_we = 1'b0;
   logic [3:0]      ctl_wdata = '0;
   logic            ext_sync = 1'b1;
   logic            load_cfg = 1'b0;
   logic [NCH-1:0]  pwm_o;
   logic            armed_o;
   logic [3:0]      ctl_o;

   int    compared = 0;
   int    mismatched = 0;
   bit    chk_on = 1'b0;
   bit    done_flag = 1'b0;
   string cur_tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_sync_gen #(.NCH(NCH), .CW(CW), .SYNC_STAGES(2), .RST_SOFT(P_SOFT),
      .RST_START_AT_SYNC(P_SAS), .RST_FORCE(P_FORCE), .RST_AUTO(P_AUTO)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
      .cfg_data(cfg_data), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ext_sync(ext_sync),
      .load_cfg(load_cfg), .pwm_o(pwm_o), .armed_o(armed_o), .ctl_o(ctl_o));

   // ---------------- reference model built from the requirements ----------------
   logic m_s1, m_s2, m_s3, m_load, m_armed, m_pend;
   logic [NCH-1:0] m_done, m_en, m_run;
   logic [3:0]     m_ctl;
   logic [CW-1:0]  m_cnt [NCH];
   logic [CW-1:0]  m_per_s [NCH], m_wid_s [NCH], m_off_s [NCH];
   logic [CW-1:0]  m_per_a [NCH], m_wid_a [NCH], m_off_a [NCH];

   function automatic int peff(logic [CW-1:0] p);
      return (p == '0) ? 1 : int'(p);
   endfunction

   function automatic logic exp_out(int c);
      int pe, cn, of, ph;
      pe = peff(m_per_a[c]);
      cn = int'(m_cnt[c]);
      of = int'(m_off_a[c]);
      ph = (cn >= of) ? cn - of : cn + pe - of;
      return m_en[c] && m_run[c] && !m_ctl[0] && (ph < int'(m_wid_a[c]));
   endfunction

   task automatic model_reset();
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_load = 0; m_armed = 0; m_pend = 0;
      m_done = '0; m_en = '0; m_run = '1;
      m_ctl = {P_AUTO, P_FORCE, P_SAS, P_SOFT};
      for (int c = 0; c < NCH; c++) begin
         m_cnt[c] = '0; m_per_s[c] = '0; m_wid_s[c] = '0; m_off_s[c] = '0;
         m_per_a[c] = '0; m_wid_a[c] = '0; m_off_a[c] = '0;
      end
   endtask

   task automatic model_step();
      logic fall, tog, sr, sas, frc, aut, trig, alldone, algn, acc;
      logic [NCH-1:0] wr;
      fall = m_s3 & ~m_s2;
      tog  = load_cfg ^ m_load;
      sr = m_ctl[0]; sas = m_ctl[1]; frc = m_ctl[2]; aut = m_ctl[3];
      trig = fall & (aut | m_armed);
      alldone = 1'b1;
      for (int c = 0; c < NCH; c++) begin
         wr[c] = m_en[c] && (int'(m_cnt[c]) == peff(m_per_a[c]) - 1);
         if (m_en[c] && !m_done[c]) alldone = 1'b0;
      end
      algn = (frc ? trig : (m_pend & alldone)) & ~sr;
      acc  = ~frc & trig & ~m_pend;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_sync; m_load = load_cfg;
      if (sr) begin
         m_armed = 0; m_pend = 0; m_done = '0;
      end else begin
         if (algn) m_armed = 0; else if (tog && !aut) m_armed = 1;
         if (acc) m_done = '0; else if (m_pend) m_done = m_done | wr;
         if (algn) m_pend = 0; else if (acc) m_pend = 1;
      end
      for (int c = 0; c < NCH; c++) begin
         if (sr || !m_en[c] || algn || wr[c]) begin
            m_run[c] = (sr || !m_en[c]) ? 1'b1 : (algn ? sas : 1'b1);
            m_cnt[c] = '0;
            m_per_a[c] = m_per_s[c]; m_wid_a[c] = m_wid_s[c]; m_off_a[c] = m_off_s[c];
         end else begin
            m_cnt[c] = m_cnt[c] + 1'b1;
         end
      end
      if (ctl_we) m_ctl = ctl_wdata;
      if (cfg_we && int'(cfg_ch) < NCH) begin
         case (cfg_sel)
            2'd0: m_per_s[cfg_ch] = cfg_data;
            2'd1: m_wid_s[cfg_ch] = cfg_data;
            2'd2: m_off_s[cfg_ch] = cfg_data;
            default: m_en[cfg_ch] = cfg_data[0];
         endcase
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_reset();
      else        model_step();
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && chk_on && !done_flag) begin
         for (int c = 0; c < NCH; c++) begin
            compared++;
            if (pwm_o[c] !== exp_out(c)) begin
               mismatched++;
               $display("FAIL %s ch%0d pwm actual %b expected %b at %0t",
                        cur_tag, c, pwm_o[c], exp_out(c), $time);
            end
         end
         compared++;
         if (armed_o !== m_armed) begin
            mismatched++;
            $display("FAIL %s armed actual %b expected %b at %0t",
                     cur_tag, armed_o, m_armed, $time);
         end
      end
   end

   task automatic check1(string tag, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // called at a negedge, returns at the next negedge (R12 field encoding)
   task automatic wr_cfg(int ch, int sel, int data);
      cfg_we = 1'b1; cfg_ch = CHW'(ch); cfg_sel = 2'(sel); cfg_data = CW'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wr_ctl(logic [3:0] v);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int sync_hold;
      void'($urandom(32'd7041));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check1("R11 reset control word", 32'(ctl_o), {28'd0, P_AUTO, P_FORCE, P_SAS, P_SOFT});
      check1("R3 reset outputs low", 32'(pwm_o), 32'd0);
      check1("R5 reset not armed", 32'(armed_o), 32'd0);
      chk_on = 1'b1;

      // R2 / R12: zero width, over-range width, one-cycle period, disabled channel
      cur_tag = "R2/R12";
      wr_cfg(0, 0, 5); wr_cfg(0, 1, 0);
      wr_cfg(1, 0, 5); wr_cfg(1, 1, 9);
      wr_cfg(2, 0, 1); wr_cfg(2, 1, 1);
      wr_cfg(0, 3, 1); wr_cfg(1, 3, 1); wr_cfg(2, 3, 1);
      for (int i = 0; i < 12; i++) begin
         check1("R2 zero width low", 32'(pwm_o[0]), 32'd0);
         check1("R2 over-range width high", 32'(pwm_o[1]), 32'd1);
         check1("R2 period one full high", 32'(pwm_o[2]), 32'd1);
         check1("R3 disabled low", 32'(pwm_o[3]), 32'd0);
         @(negedge clk);
      end

      // R7 / R9: auto, force, start-at-sync off
      cur_tag = "R6/R7/R9";
      wr_ctl(4'b1100);
      wr_cfg(0, 0, 4); wr_cfg(0, 1, 2);
      repeat (12) @(negedge clk);
      ext_sync = 1'b0;                    // sampled 0 at edge k
      repeat (6) @(posedge clk);          // edges k..k+5
      @(negedge clk);
      check1("R9 delay low ch0", 32'(pwm_o[0]), 32'd0);
      check1("R9 delay low full-width ch1", 32'(pwm_o[1]), 32'd0);
      @(posedge clk);                     // edge k+6
      @(negedge clk);
      check1("R7 aligned ch0 first high", 32'(pwm_o[0]), 32'd1);
      check1("R9 ch1 still delayed", 32'(pwm_o[1]), 32'd0);
      ext_sync = 1'b1;
      repeat (10) @(negedge clk);

      // R5: manual arming
      cur_tag = "R5";
      wr_ctl(4'b0110);
      load_cfg = ~load_cfg;
      @(negedge clk);
      check1("R5 armed after toggle", 32'(armed_o), 32'd1);
      ext_sync = 1'b0;
      repeat (3) @(negedge clk);
      check1("R5 armed cleared by align", 32'(armed_o), 32'd0);
      ext_sync = 1'b1;
      repeat (8) @(negedge clk);

      // constrained random mix over all modes
      cur_tag = "R1/R4/R5/R6/R8/R9/R10";
      sync_hold = 20;
      for (int cyc = 0; cyc < 30000; cyc++) begin
         int r, c, sel;
         cfg_we = 1'b0; ctl_we = 1'b0;
         r = int'($urandom % 100);
         if (r < 3) begin
            c = int'($urandom % NCH);
            sel = int'($urandom % 4);
            cfg_we = 1'b1; cfg_ch = CHW'(c); cfg_sel = 2'(sel);
            case (sel)
               0: begin
                  if (m_off_s[c] >= 8) begin cfg_sel = 2'd2; cfg_data = '0; end
                  else if (m_off_s[c] == 0 && $urandom % 10 == 0) cfg_data = '0;
                  else cfg_data = m_off_s[c] + CW'(1 + $urandom % 7);
               end
               1: cfg_data = CW'($urandom % 14);
               2: cfg_data = CW'($urandom % peff(m_per_s[c]));
               default: cfg_data = CW'($urandom % 4 != 0);
            endcase
         end else if (r < 4) begin
            ctl_we = 1'b1;
            ctl_wdata = {$urandom % 2 == 0, $urandom % 2 == 0, $urandom % 2 == 0,
                         $urandom % 8 == 0};
         end
         if ($urandom % 60 == 0) load_cfg = ~load_cfg;
         sync_hold--;
         if (sync_hold <= 0) begin
            ext_sync = ~ext_sync;
            sync_hold = ext_sync ? int'(5 + $urandom % 40) : int'(1 + $urandom % 6);
         end
         @(negedge clk);
      end
      cfg_we = 1'b0; ctl_we = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule